// File: doc/BRIEF.md
# Two-Stage Scaler Coefficient Calculator

This block works out the settings for an image resizer built from two parts in series: a pre-decimator that halves the data zero, one or two times, followed by a fractional interpolator whose step is a 14-bit fixed-point value in which 8192 stands for a ratio of 1.0. For each of the horizontal and vertical axes the block takes an input size and a wanted output size. It selects the number of halvings, divides to get the step, and checks the request against the limits of the resizer. Either axis can instead take a fixed step directly.

A request is made with a one-cycle `start` pulse while the block is idle. Both axes then pass one after the other through a single restoring divider that yields one quotient bit per clock. That gives a fixed latency. The result appears as a one-cycle `done` pulse, a set of error flags, and a 32-bit packed resize word. The word changes only when neither axis has an error, so the resizer can take it as a whole.

Top module: `scl_coef_calc`

## Requirements
- R1: While `rst_n` is low, `rsz_word` and `err_flags` are zero and `busy` and `done` are low.
- R2: Flag bit 0 is set when an axis that is not bypassed has an input size of 0 or greater than 4096.
- R3: Flag bit 1 is set when an axis that is not bypassed has an output size below 2 or greater than 1024.
- R4: Flag bit 2 is set when an axis that is not bypassed has an output size which, multiplied by 8, is less than its input size.
- R5: The downsize code begins at 0, with the working size equal to the input size. The working size is halved with truncation, and the code raised by one, at most twice, for as long as the working size is above 1024 or at least twice the output size.
- R6: The step is floor(8192 × (working size − 1) / (output size − 1)).
- R7: Flag bit 3 is set when the step of a computed axis is 16384 or more. It is only evaluated on an axis that has no bit 0 to 2 error.
- R8: An axis ratio input that is nonzero and below 16384 bypasses the calculation. Its value becomes the step, the code is 0, and that axis's sizes raise no flag.
- R9: The packed word holds the vertical code in bits 31:30, the vertical step in 29:16, the horizontal code in 15:14 and the horizontal step in 13:0.
- R10: `rsz_word` is loaded only at `done`, and only when the flags of both axes are clear. The flags are the OR over both axes and stay unchanged until the next `done`.
- R11: `done` is a one-cycle pulse that comes 56 rising edges after the edge that samples an accepted `start`. `busy` is high from that edge up to the `done` edge.
- R12: A `start` seen while `busy` is high is ignored. The run in progress keeps its inputs and its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calculation (taken only when idle) |
| h_in_size | input | 13 | Horizontal input size in pixels |
| h_out_size | input | 13 | Horizontal output size in pixels |
| h_ratio | input | 15 | Horizontal direct step, 0 or ≥16384 means compute |
| v_in_size | input | 13 | Vertical input size in lines |
| v_out_size | input | 13 | Vertical output size in lines |
| v_ratio | input | 15 | Vertical direct step, 0 or ≥16384 means compute |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_flags | output | 4 | {overflow, ratio, output size, input size} |
| rsz_word | output | 32 | Packed resize control word |

## Verification
A wrong sequencer state or a miscounted divider shows up at the ports as `done` coming at a cycle other than the 56th, or as `busy` and `done` overlapping. This is visible on the first request. A wrong remainder or quotient shift shows up as a step that is off by a small amount or is scaled, in the very next word. The vectors include exact divisions and divisions with large remainders on purpose, so that both kinds of error are caught. Errors in decimation or in the flags show up either as a wrong code field or as a word that is held or updated when it should not be, at the `done` of that request.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int SIZE_W = 13;
  localparam int FRAC_W = 13;
  localparam int STEP_W = FRAC_W + 1;
  localparam int CODE_W = 2;
  localparam int HALF_W = CODE_W + STEP_W;
  localparam int WORD_W = 2 * HALF_W;
  localparam int RAT_W  = STEP_W + 1;
  localparam int ERR_W  = 4;

  localparam int ERR_IN    = 0;
  localparam int ERR_OUT   = 1;
  localparam int ERR_RATIO = 2;
  localparam int ERR_OVF   = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DIV
  } seq_state_e;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [STEP_W-1:0] step;
  } axis_res_t;
endpackage

// File: rtl/scl_axis_prep.sv
module scl_axis_prep
  import scl_pkg::*;
#(
  parameter int MAX_IN    = 4096,
  parameter int MAX_OUT   = 1024,
  parameter int RATIO_SH  = 3,
  parameter int MAX_HALVE = 2
) (
  input  logic [SIZE_W-1:0]        in_size,
  input  logic [SIZE_W-1:0]        out_size,
  input  logic [RAT_W-1:0]         ratio,
  output logic                     bypass,
  output logic [ERR_W-2:0]         lim_err,
  output logic [CODE_W-1:0]        code,
  output logic [SIZE_W+FRAC_W-1:0] dividend,
  output logic [SIZE_W-1:0]        divisor
);
  localparam int DVD_W = SIZE_W + FRAC_W;

  logic [MAX_HALVE:0][SIZE_W-1:0] ws;
  logic [MAX_HALVE:0][CODE_W-1:0] cd;
  logic [SIZE_W:0]                out_x2;
  logic [SIZE_W+RATIO_SH-1:0]     out_sh;
  logic [SIZE_W+RATIO_SH-1:0]     in_ext;
  logic                           e_in, e_out, e_rat;
  logic [SIZE_W-1:0]              ws_m1;

  // a step below 2^STEP_W has the top ratio bit clear
  assign bypass = (ratio != '0) && !ratio[RAT_W-1];

  assign out_x2 = {out_size, 1'b0};
  assign out_sh = {out_size, RATIO_SH'(0)};
  assign in_ext = {RATIO_SH'(0), in_size};

  assign e_in  = (in_size == '0) || (in_size > SIZE_W'(MAX_IN));
  assign e_out = (out_size < SIZE_W'(2)) || (out_size > SIZE_W'(MAX_OUT));
  assign e_rat = (out_sh < in_ext);

  always_comb begin
    lim_err            = '0;
    lim_err[ERR_IN]    = e_in  && !bypass;
    lim_err[ERR_OUT]   = e_out && !bypass;
    lim_err[ERR_RATIO] = e_rat && !bypass;
  end

  assign ws[0] = in_size;
  assign cd[0] = '0;

  // one halving stage per permitted pre-decimation step
  for (genvar g = 0; g < MAX_HALVE; g++) begin : g_halve
    logic shrink;
    assign shrink    = (ws[g] > SIZE_W'(MAX_OUT)) || ({1'b0, ws[g]} >= out_x2);
    assign ws[g+1]   = shrink ? (ws[g] >> 1) : ws[g];
    assign cd[g+1]   = shrink ? (cd[g] + 1'b1) : cd[g];
  end

  assign code  = cd[MAX_HALVE];
  assign ws_m1 = ws[MAX_HALVE] - 1'b1;

  // a rejected or bypassed axis feeds a harmless 0 / 1 division
  assign dividend = (e_in || e_out || e_rat || bypass) ? DVD_W'(0) : {ws_m1, FRAC_W'(0)};
  assign divisor  = (e_in || e_out || e_rat || bypass) ? SIZE_W'(1) : (out_size - 1'b1);
endmodule

// File: rtl/scl_restoring_div.sv
module scl_restoring_div #(
  parameter int DVD_W = 26,
  parameter int DSR_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DSR_W-1:0] divisor,
  output logic             busy,
  output logic [DVD_W-1:0] quotient
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DSR_W-1:0] rem_q, rem_d;
  logic [DSR_W-1:0] dsr_q, dsr_d;
  logic [DVD_W-1:0] quo_q, quo_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DSR_W:0]   trial;
  logic [DSR_W:0]   diff;
  logic             fits;
  logic             step_en;

  assign step_en = load || (cnt_q != '0);
  assign trial   = {rem_q, quo_q[DVD_W-1]};
  assign diff    = trial - {1'b0, dsr_q};
  assign fits    = (trial >= {1'b0, dsr_q});

  always_comb begin
    rem_d = rem_q;
    dsr_d = dsr_q;
    quo_d = quo_q;
    cnt_d = cnt_q;
    if (load) begin
      rem_d = '0;
      dsr_d = divisor;
      quo_d = dividend;
      cnt_d = CNT_W'(DVD_W);
    end else if (cnt_q != '0) begin
      rem_d = fits ? diff[DSR_W-1:0] : trial[DSR_W-1:0];
      quo_d = {quo_q[DVD_W-2:0], fits};
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      dsr_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
    end else if (step_en) begin
      rem_q <= rem_d;
      dsr_q <= dsr_d;
      quo_q <= quo_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy     = (cnt_q != '0);
  assign quotient = quo_q;
endmodule

// File: rtl/scl_coef_calc.sv
module scl_coef_calc
  import scl_pkg::*;
#(
  parameter int MAX_IN    = 4096,
  parameter int MAX_OUT   = 1024,
  parameter int RATIO_SH  = 3,
  parameter int MAX_HALVE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SIZE_W-1:0] h_in_size,
  input  logic [SIZE_W-1:0] h_out_size,
  input  logic [RAT_W-1:0]  h_ratio,
  input  logic [SIZE_W-1:0] v_in_size,
  input  logic [SIZE_W-1:0] v_out_size,
  input  logic [RAT_W-1:0]  v_ratio,
  output logic              busy,
  output logic              done,
  output logic [ERR_W-1:0]  err_flags,
  output logic [WORD_W-1:0] rsz_word
);
  localparam int DVD_W   = SIZE_W + FRAC_W;
  localparam int LATENCY = 2 * (DVD_W + 2);

  seq_state_e        state_q, state_d;
  logic              axis_q, axis_d;
  logic [SIZE_W-1:0] hi_q, ho_q, vi_q, vo_q;
  logic [RAT_W-1:0]  hr_q, vr_q;
  axis_res_t         hres_q;
  logic [ERR_W-1:0]  acc_q, err_q;
  logic [WORD_W-1:0] word_q;
  logic              done_q, done_d;
  logic              req_en, hres_en, fin_en, word_en;

  logic [SIZE_W-1:0] cur_in, cur_out;
  logic [RAT_W-1:0]  cur_rat;
  logic              p_bypass;
  logic [ERR_W-2:0]  p_err;
  logic [CODE_W-1:0] p_code;
  logic [DVD_W-1:0]  p_dvd;
  logic [SIZE_W-1:0] p_dsr;
  logic              div_load, div_busy;
  logic [DVD_W-1:0]  div_quo;
  logic              ovf;
  logic [ERR_W-1:0]  ax_err, all_err;
  axis_res_t         ax_res;

  assign cur_in  = axis_q ? vi_q : hi_q;
  assign cur_out = axis_q ? vo_q : ho_q;
  assign cur_rat = axis_q ? vr_q : hr_q;

  scl_axis_prep #(
    .MAX_IN   (MAX_IN),
    .MAX_OUT  (MAX_OUT),
    .RATIO_SH (RATIO_SH),
    .MAX_HALVE(MAX_HALVE)
  ) u_prep (
    .in_size (cur_in),
    .out_size(cur_out),
    .ratio   (cur_rat),
    .bypass  (p_bypass),
    .lim_err (p_err),
    .code    (p_code),
    .dividend(p_dvd),
    .divisor (p_dsr)
  );

  assign div_load = (state_q == ST_LOAD);

  scl_restoring_div #(
    .DVD_W(DVD_W),
    .DSR_W(SIZE_W)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (div_load),
    .dividend(p_dvd),
    .divisor (p_dsr),
    .busy    (div_busy),
    .quotient(div_quo)
  );

  // quotient bits above the step field mean the step does not fit
  assign ovf = !p_bypass && (p_err == '0) && (|div_quo[DVD_W-1:STEP_W]);

  always_comb begin
    ax_err          = {1'b0, p_err};
    ax_err[ERR_OVF] = ovf;
    if (p_bypass) begin
      ax_res.code = '0;
      ax_res.step = cur_rat[STEP_W-1:0];
    end else begin
      ax_res.code = p_code;
      ax_res.step = div_quo[STEP_W-1:0];
    end
  end

  assign all_err = acc_q | ax_err;

  always_comb begin
    state_d = state_q;
    axis_d  = axis_q;
    req_en  = 1'b0;
    hres_en = 1'b0;
    fin_en  = 1'b0;
    word_en = 1'b0;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          req_en  = 1'b1;
          axis_d  = 1'b0;
          state_d = ST_LOAD;
        end
      end
      ST_LOAD: state_d = ST_DIV;
      ST_DIV: begin
        if (!div_busy) begin
          if (!axis_q) begin
            hres_en = 1'b1;
            axis_d  = 1'b1;
            state_d = ST_LOAD;
          end else begin
            fin_en  = 1'b1;
            word_en = (all_err == '0);
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      axis_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      axis_q  <= axis_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      ho_q <= '0;
      hr_q <= '0;
      vi_q <= '0;
      vo_q <= '0;
      vr_q <= '0;
    end else if (req_en) begin
      hi_q <= h_in_size;
      ho_q <= h_out_size;
      hr_q <= h_ratio;
      vi_q <= v_in_size;
      vo_q <= v_out_size;
      vr_q <= v_ratio;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hres_q <= '0;
      acc_q  <= '0;
    end else if (hres_en) begin
      hres_q <= ax_res;
      acc_q  <= ax_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
    end else if (fin_en) begin
      err_q <= all_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= {ax_res, hres_q};
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign err_flags = err_q;
  assign rsz_word  = word_q;
endmodule

// File: rtl/scl_coef_calc_chk.sv
module scl_coef_calc_chk
  import scl_pkg::*;
#(
  parameter int LAT = 56
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [ERR_W-1:0]  err_flags,
  input logic [WORD_W-1:0] rsz_word
);
  logic [15:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt <= '0;
    end else if (start && !busy) begin
      lat_cnt <= '0;
    end else if (busy) begin
      lat_cnt <= lat_cnt + 1'b1;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |-> (rsz_word == '0) && (err_flags == '0) && !busy && !done);

  p_code_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsz_word[WORD_W-1 -: CODE_W] != '1) && (rsz_word[HALF_W-1 -: CODE_W] != '1));

  p_word_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rsz_word));

  p_err_blocks_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (err_flags != '0)) |-> $stable(rsz_word));

  p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(err_flags));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_start_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == 16'(LAT)));
endmodule

bind scl_coef_calc scl_coef_calc_chk #(.LAT(LATENCY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .err_flags(err_flags),
  .rsz_word (rsz_word)
);

// File: tb/test_scl_coef_calc.sv
module test_scl_coef_calc;
  import scl_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int EXP_LAT    = 56;

  typedef struct packed {
    logic [12:0] hi;
    logic [12:0] ho;
    logic [14:0] hr;
    logic [12:0] vi;
    logic [12:0] vo;
    logic [14:0] vr;
    logic [3:0]  err;
    logic [31:0] word;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{13'd640,  13'd320,  15'd0,      13'd480,  13'd240,  15'd0,     4'h0, 32'h6000_6000}, // R5 halve once, R6 exact
    '{13'd320,  13'd640,  15'd0,      13'd240,  13'd480,  15'd0,     4'h0, 32'h0FF7_0FF9}, // R6 truncating upscale
    '{13'd4096, 13'd1024, 15'd0,      13'd4096, 13'd1024, 15'd0,     4'h0, 32'hA000_A000}, // R5 two halvings, limits
    '{13'd1000, 13'd700,  15'd0,      13'd100,  13'd100,  15'd0,     4'h0, 32'h2000_2DBB}, // R6 remainder, R9 layout
    '{13'd198,  13'd100,  15'd0,      13'd198,  13'd100,  15'd0,     4'h0, 32'h3FAD_3FAD}, // R7 just below overflow
    '{13'd199,  13'd100,  15'd0,      13'd100,  13'd100,  15'd0,     4'h8, 32'h3FAD_3FAD}, // R7 step 16384
    '{13'd4097, 13'd1024, 15'd0,      13'd100,  13'd100,  15'd0,     4'h1, 32'h3FAD_3FAD}, // R2
    '{13'd1000, 13'd1025, 15'd0,      13'd100,  13'd100,  15'd0,     4'h2, 32'h3FAD_3FAD}, // R3
    '{13'd801,  13'd100,  15'd0,      13'd100,  13'd100,  15'd0,     4'h4, 32'h3FAD_3FAD}, // R4
    '{13'd800,  13'd100,  15'd0,      13'd100,  13'd100,  15'd0,     4'h8, 32'h3FAD_3FAD}, // R4 edge passes, R7
    '{13'd5000, 13'd1,    15'h1234,   13'd640,  13'd320,  15'h4000,  4'h0, 32'h6000_1234}, // R8 bypass
    '{13'd100,  13'd100,  15'd0,      13'd0,    13'd100,  15'd0,     4'h1, 32'h6000_1234}, // R2 vertical, R10
    '{13'd8,    13'd1,    15'd0,      13'd100,  13'd100,  15'd0,     4'h2, 32'h6000_1234}, // R3 size 1
    '{13'd100,  13'd100,  15'h3FFF,   13'd100,  13'd100,  15'h4000,  4'h0, 32'h2000_3FFF}  // R8 largest step
  };

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [SIZE_W-1:0] h_in_size, h_out_size, v_in_size, v_out_size;
  logic [RAT_W-1:0]  h_ratio, v_ratio;
  logic              busy, done;
  logic [ERR_W-1:0]  err_flags;
  logic [WORD_W-1:0] rsz_word;

  int checks = 0;
  int fails  = 0;

  scl_coef_calc i_scl_coef_calc (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .h_in_size (h_in_size),
    .h_out_size(h_out_size),
    .h_ratio   (h_ratio),
    .v_in_size (v_in_size),
    .v_out_size(v_out_size),
    .v_ratio   (v_ratio),
    .busy      (busy),
    .done      (done),
    .err_flags (err_flags),
    .rsz_word  (rsz_word)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    h_in_size  = v.hi;
    h_out_size = v.ho;
    h_ratio    = v.hr;
    v_in_size  = v.vi;
    v_out_size = v.vo;
    v_ratio    = v.vr;
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!done && n < 500);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int n2;
    vec_t alt;
    rst_n = 1'b0;
    start = 1'b0;
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "word in reset", rsz_word, 32'h0);
    chk("R1", "flags in reset", 32'(err_flags), 32'h0);
    chk("R1", "busy in reset", 32'(busy), 32'h0);
    chk("R1", "done in reset", 32'(done), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 latency, busy, single-cycle done
    launch(VECS[0]);
    chk("R11", "busy during run", 32'(busy), 32'h1);
    wait_done(n);
    chk("R11", "done latency", 32'(n), 32'(EXP_LAT));
    chk("R11", "busy at done", 32'(busy), 32'h0);
    @(negedge clk);
    chk("R11", "done one cycle", 32'(done), 32'h0);

    // R12 start while busy is ignored
    launch(VECS[3]);
    repeat (10) begin
      @(posedge clk);
      @(negedge clk);
    end
    alt = VECS[1];
    drive(alt);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    wait_done(n2);
    chk("R12", "latency with extra start", 32'(n2 + 11), 32'(EXP_LAT));
    chk("R12", "word from first request", rsz_word, VECS[3].word);
    repeat (70) @(negedge clk);
    chk("R12", "no second run", 32'(busy), 32'h0);

    // table of vectors
    for (int i = 0; i < NV; i++) begin
      string tag;
      launch(VECS[i]);
      wait_done(n);
      case (VECS[i].err)
        4'h1:    tag = "R2";
        4'h2:    tag = "R3";
        4'h4:    tag = "R4";
        4'h8:    tag = "R7";
        default: tag = (VECS[i].hr != '0) ? "R8" : "R6";
      endcase
      chk(tag, $sformatf("flags row %0d", i), 32'(err_flags), 32'(VECS[i].err));
      if (VECS[i].err != 4'h0)
        chk("R10", $sformatf("word held row %0d", i), rsz_word, VECS[i].word);
      else if (i == 2)
        chk("R5", $sformatf("codes row %0d", i), rsz_word, VECS[i].word);
      else
        chk("R9", $sformatf("word row %0d", i), rsz_word, VECS[i].word);
    end

    // R10 flags stay until the next completion
    repeat (20) @(negedge clk);
    chk("R10", "flags unchanged after idle", 32'(err_flags), 32'h0);
    launch(VECS[6]);
    wait_done(n);
    repeat (25) @(negedge clk);
    chk("R10", "error flags held", 32'(err_flags), 32'h1);

    // R1 reset in the middle of a run
    launch(VECS[0]);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "word after mid-run reset", rsz_word, 32'h0);
    chk("R1", "busy after mid-run reset", 32'(busy), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule